// File: doc/BRIEF.md
# Dual-Table Reconfigurable Logic Cell

This block is one logic cell of a row-organised configurable datapath. It holds two small lookup tables, each taking four address bits and returning two data bits. A two-level output selector, steered by the two remaining routed inputs, joins the tables into one of four functions:

- a 4-input/4-output function;
- a 5-input/2-output function;
- a 6-input/1-output function;
- a 2-bit carry-select adder, in which the dedicated carry logic supplies the carry-out and the signed overflow.

Four output registers capture the result only while the row is enabled. One input position can be replaced by a feedback value, so the cell can hold state such as an accumulator bit. A select-controlled feedback multiplexer supplies that value. While state initialisation is asserted, it gives either a constant or a routed input. Otherwise it gives one of the cell's own outputs or another routed input.

The table contents can be rewritten at run time by a burst mechanism. Each write cycle takes four 2-bit data lanes, one 8-bit word, from register-file data. A saturating 3-bit address counter steps through the eight words of the two tables, so both tables are refilled in eight consecutive cycles.

Top module: `dual_lut_cell`

## Requirements
- R1: With cfg_mode = 0 (4:4), on a loading edge cell_q[1:0] becomes table 0 entry e[3:0] and cell_q[3:2] becomes table 1 entry e[3:0]. Here e is the effective input vector: cell_in, with bit 3 replaced by the feedback value when cfg_fb_en = 1.
- R2: With cfg_mode = 1 (5:2), cell_q[1:0] loads the entry at e[3:0] of table 1 when e[4] = 1 and of table 0 when e[4] = 0. cell_q[3:2] loads 0 and e[5] has no effect.
- R3: With cfg_mode = 2 (6:1), cell_q[0] loads bit e[5] of the 2-bit entry chosen as in R2, and cell_q[3:1] loads 0.
- R4: The output registers load only on an edge where row_en = 1; with row_en = 0 they keep their value.
- R5: With cfg_fb_en = 1, e[3] is the feedback value. When state_init = 1 it is cfg_init_const if cfg_init_src = 0, else cell_in[5]. When state_init = 0 it is cell_q[cfg_loop_sel] if cfg_run_src = 0, else cell_in[4].
- R6: With cfg_mode = 3 (adder), a = e[1:0], b = e[3:2] and cin = e[4]. cell_q[1:0] loads the table-1 entry when cin = 1 and the table-0 entry when cin = 0. cell_q[2] loads the carry-out of a+b+cin, and cell_q[3] loads the overflow of that sum read as 2-bit two's complement.
- R7: Each edge with burst_on = 1, burst_init = 0 and the counter not finished writes burst_lanes to word n, where n is the counter value. Word n goes to table n[2], and lane k (burst_lanes[2k+1:2k]) goes to entry 4*(n mod 4)+k. The counter then advances by one. An edge with burst_init = 1 clears the counter and writes nothing.
- R8: After word 7 is written, the counter is finished. Further burst_on cycles change no table entry until burst_init is asserted.
- R9: On an edge where a burst word is written, the output registers keep their value even with row_en = 1.
- R10: After reset, cell_q is 0, every table entry is 0 and the burst counter is at word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_in | input | 6 | Routed inputs |
| row_en | input | 1 | Row enable for the output registers |
| state_init | input | 1 | State-initialisation phase for the feedback multiplexer |
| burst_init | input | 1 | Clears the burst address counter |
| burst_on | input | 1 | Writes one burst word and advances the counter |
| burst_lanes | input | 8 | Four 2-bit burst data lanes, lane k at bits 2k+1:2k |
| cfg_mode | input | 2 | Function mode: 0 4:4, 1 5:2, 2 6:1, 3 adder |
| cfg_fb_en | input | 1 | Replaces input bit 3 with the feedback value |
| cfg_init_src | input | 1 | Feedback source during initialisation: 0 constant, 1 cell_in[5] |
| cfg_init_const | input | 1 | Constant used during initialisation |
| cfg_run_src | input | 1 | Feedback source in normal operation: 0 own output, 1 cell_in[4] |
| cfg_loop_sel | input | 2 | Which output is fed back |
| cell_q | output | 4 | Registered outputs |

## Verification
The tables are filled by burst with three contents, and each content exposes a different class of fault.

An identity content makes the outputs echo the effective inputs. Under it, each feedback source and the row enable can be seen directly.

A pseudo-random word pattern is swept over every input value in the 4:4, 5:2 and 6:1 modes. This separates the two tables, the order of words and lanes, and the selector bits.

Adder contents are swept over all operand and carry combinations. The carry-out and the overflow are checked against arithmetic done in the bench.

Extra burst cycles after the counter finishes, and a partial rewrite after a counter clear, show saturation, clearing, and hold of the outputs during writes.

// File: rtl/dlc_pkg.sv
package dlc_pkg;

   typedef enum logic [1:0] {
      MODE_WIDE4 = 2'd0,
      MODE_SEL5  = 2'd1,
      MODE_SEL6  = 2'd2,
      MODE_ADD2  = 2'd3
   } dlc_mode_e;

   localparam int FB_SRC_CONST = 0;
   localparam int FB_SRC_INA   = 1;
   localparam int FB_SRC_LOOP  = 2;
   localparam int FB_SRC_INB   = 3;

endpackage

// File: rtl/dlc_burst_ctr.sv
module dlc_burst_ctr #(
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              burst_init,
   input  logic              burst_on,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              done
);
   localparam int LAST = (1 << ADDR_W) - 1;

   if (ADDR_W < 1) begin : g_bad_addr_w
      $error("dlc_burst_ctr: ADDR_W must be at least 1");
   end

   assign wr_en = burst_on && !done && !burst_init;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_addr <= '0;
         done    <= 1'b0;
      end else if (burst_init) begin
         wr_addr <= '0;
         done    <= 1'b0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_W'(LAST)) begin
            done <= 1'b1;
         end else begin
            wr_addr <= wr_addr + 1'b1;
         end
      end
   end
endmodule

// File: rtl/dlc_lut_store.sv
module dlc_lut_store #(
   parameter int LUT_IN    = 4,
   parameter int LUT_OUT   = 2,
   parameter int NUM_LUTS  = 2,
   parameter int LANE_W    = 2,
   parameter int NUM_LANES = 4,
   localparam int WORD_W   = LANE_W * NUM_LANES,
   localparam int ENTRIES  = 1 << LUT_IN,
   localparam int LUT_BITS = ENTRIES * LUT_OUT,
   localparam int WPL      = LUT_BITS / WORD_W,
   localparam int ADDR_W   = $clog2(NUM_LUTS * WPL)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [ADDR_W-1:0]                 wr_addr,
   input  logic [WORD_W-1:0]                 wr_data,
   input  logic [LUT_IN-1:0]                 rd_addr,
   output logic [NUM_LUTS-1:0][LUT_OUT-1:0]  rd_data
);
   if (LANE_W != LUT_OUT) begin : g_bad_lane
      $error("dlc_lut_store: a lane must carry exactly one table entry");
   end
   if (LUT_BITS % WORD_W != 0) begin : g_bad_word
      $error("dlc_lut_store: table size must be a whole number of words");
   end

   for (genvar t = 0; t < NUM_LUTS; t++) begin : g_lut
      logic [LUT_BITS-1:0] cells;

      for (genvar w = 0; w < WPL; w++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cells[w*WORD_W +: WORD_W] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(t * WPL + w))) begin
               cells[w*WORD_W +: WORD_W] <= wr_data;
            end
         end
      end

      assign rd_data[t] = cells[int'(rd_addr) * LUT_OUT +: LUT_OUT];
   end
endmodule

// File: rtl/dlc_fb_mux.sv
module dlc_fb_mux #(
   parameter int NUM_OUT = 4,
   localparam int SEL_W  = $clog2(NUM_OUT)
) (
   input  logic               state_init,
   input  logic               cfg_init_src,
   input  logic               cfg_init_const,
   input  logic               cfg_run_src,
   input  logic [SEL_W-1:0]   cfg_loop_sel,
   input  logic [NUM_OUT-1:0] q_loop,
   input  logic               in_init,
   input  logic               in_run,
   output logic               fb
);
   import dlc_pkg::*;

   logic [1:0] sel;

   assign sel = state_init ? {1'b0, cfg_init_src} : {1'b1, cfg_run_src};

   always_comb begin
      case (int'(sel))
         FB_SRC_CONST: fb = cfg_init_const;
         FB_SRC_INA:   fb = in_init;
         FB_SRC_LOOP:  fb = q_loop[cfg_loop_sel];
         default:      fb = in_run;
      endcase
   end
endmodule

// File: rtl/dlc_out_comb.sv
module dlc_out_comb #(
   parameter int LUT_IN   = 4,
   parameter int LUT_OUT  = 2,
   parameter int NUM_LUTS = 2,
   localparam int NUM_IN  = LUT_IN + 2,
   localparam int NUM_OUT = NUM_LUTS * LUT_OUT,
   localparam int HALF    = LUT_IN / 2
) (
   input  logic [1:0]                        cfg_mode,
   input  logic [NUM_IN-1:0]                 e,
   input  logic [NUM_LUTS-1:0][LUT_OUT-1:0]  lut_q,
   output logic [NUM_OUT-1:0]                d
);
   import dlc_pkg::*;

   if (NUM_LUTS != 2 || LUT_OUT != 2 || LUT_IN != 4) begin : g_bad_shape
      $error("dlc_out_comb: selector is built for two 4:2 tables");
   end

   dlc_mode_e          mode;
   logic [LUT_OUT-1:0] pair;
   logic               sel_bit;
   logic [HALF-1:0]    op_a;
   logic [HALF-1:0]    op_b;
   logic [HALF:0]      add_sum;
   logic               cout;
   logic               ovf;

   assign mode    = dlc_mode_e'(cfg_mode);
   assign pair    = e[LUT_IN] ? lut_q[1] : lut_q[0];
   assign sel_bit = pair[e[LUT_IN+1]];

   assign op_a    = e[HALF-1:0];
   assign op_b    = e[LUT_IN-1:HALF];
   assign add_sum = {1'b0, op_a} + {1'b0, op_b} + {{HALF{1'b0}}, e[LUT_IN]};
   assign cout    = add_sum[HALF];
   assign ovf     = (op_a[HALF-1] == op_b[HALF-1]) && (add_sum[HALF-1] != op_a[HALF-1]);

   always_comb begin
      d = '0;
      case (mode)
         MODE_WIDE4: d = {lut_q[1], lut_q[0]};
         MODE_SEL5:  d[LUT_OUT-1:0] = pair;
         MODE_SEL6:  d[0] = sel_bit;
         default:    d = {ovf, cout, pair};
      endcase
   end
endmodule

// File: rtl/dual_lut_cell.sv
module dual_lut_cell #(
   parameter int LUT_IN    = 4,
   parameter int LUT_OUT   = 2,
   parameter int NUM_LUTS  = 2,
   parameter int LANE_W    = 2,
   parameter int NUM_LANES = 4,
   localparam int NUM_IN   = LUT_IN + 2,
   localparam int NUM_OUT  = NUM_LUTS * LUT_OUT,
   localparam int SEL_W    = $clog2(NUM_OUT),
   localparam int LANE_BITS = LANE_W * NUM_LANES
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_IN-1:0]    cell_in,
   input  logic                 row_en,
   input  logic                 state_init,
   input  logic                 burst_init,
   input  logic                 burst_on,
   input  logic [LANE_BITS-1:0] burst_lanes,
   input  logic [1:0]           cfg_mode,
   input  logic                 cfg_fb_en,
   input  logic                 cfg_init_src,
   input  logic                 cfg_init_const,
   input  logic                 cfg_run_src,
   input  logic [SEL_W-1:0]     cfg_loop_sel,
   output logic [NUM_OUT-1:0]   cell_q
);
   localparam int ENTRIES = 1 << LUT_IN;
   localparam int WPL     = (ENTRIES * LUT_OUT) / LANE_BITS;
   localparam int ADDR_W  = $clog2(NUM_LUTS * WPL);
   localparam int FB_POS  = LUT_IN - 1;

   if (ADDR_W != 3) begin : g_bad_ctr
      $error("dual_lut_cell: burst counter is expected to be 3 bits wide");
   end

   logic [ADDR_W-1:0]                burst_addr;
   logic                             burst_wr;
   logic                             burst_done;
   logic                             fb_val;
   logic [NUM_IN-1:0]                eff_in;
   logic [NUM_LUTS-1:0][LUT_OUT-1:0] lut_q;
   logic [NUM_OUT-1:0]               next_q;

   dlc_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .burst_init (burst_init),
      .burst_on   (burst_on),
      .wr_en      (burst_wr),
      .wr_addr    (burst_addr),
      .done       (burst_done)
   );

   dlc_fb_mux #(.NUM_OUT(NUM_OUT)) u_fb (
      .state_init     (state_init),
      .cfg_init_src   (cfg_init_src),
      .cfg_init_const (cfg_init_const),
      .cfg_run_src    (cfg_run_src),
      .cfg_loop_sel   (cfg_loop_sel),
      .q_loop         (cell_q),
      .in_init        (cell_in[NUM_IN-1]),
      .in_run         (cell_in[NUM_IN-2]),
      .fb             (fb_val)
   );

   always_comb begin
      eff_in = cell_in;
      if (cfg_fb_en) begin
         eff_in[FB_POS] = fb_val;
      end
   end

   dlc_lut_store #(
      .LUT_IN    (LUT_IN),
      .LUT_OUT   (LUT_OUT),
      .NUM_LUTS  (NUM_LUTS),
      .LANE_W    (LANE_W),
      .NUM_LANES (NUM_LANES)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (burst_wr),
      .wr_addr (burst_addr),
      .wr_data (burst_lanes),
      .rd_addr (eff_in[LUT_IN-1:0]),
      .rd_data (lut_q)
   );

   dlc_out_comb #(
      .LUT_IN   (LUT_IN),
      .LUT_OUT  (LUT_OUT),
      .NUM_LUTS (NUM_LUTS)
   ) u_comb (
      .cfg_mode (cfg_mode),
      .e        (eff_in),
      .lut_q    (lut_q),
      .d        (next_q)
   );

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_oreg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cell_q[i] <= 1'b0;
         end else if (row_en && !burst_wr) begin
            cell_q[i] <= next_q[i];
         end
      end
   end
endmodule

// File: rtl/dual_lut_cell_chk.sv
module dual_lut_cell_chk #(
   parameter int NUM_IN  = 6,
   parameter int NUM_OUT = 4,
   parameter int ADDR_W  = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_IN-1:0]  cell_in,
   input logic               row_en,
   input logic               burst_init,
   input logic [1:0]         cfg_mode,
   input logic               cfg_fb_en,
   input logic [NUM_OUT-1:0] cell_q,
   input logic               burst_wr,
   input logic               burst_done,
   input logic [ADDR_W-1:0]  burst_addr
);
   localparam int LAST = (1 << ADDR_W) - 1;

   logic [2:0] chk_sum;
   assign chk_sum = {1'b0, cell_in[1:0]} + {1'b0, cell_in[3:2]} + {2'b00, cell_in[4]};

   a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !row_en |=> $stable(cell_q));

   a_r9_hold_during_burst: assert property (@(posedge clk) disable iff (!rst_n)
      burst_wr |=> $stable(cell_q));

   a_r8_counter_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_done && !burst_init) |=> (burst_done && $stable(burst_addr)));

   a_r7_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
      burst_init |=> (burst_addr == '0 && !burst_done));

   a_r7_counter_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_wr && burst_addr != ADDR_W'(LAST)) |=> (burst_addr == $past(burst_addr) + 1'b1));

   a_r3_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (row_en && !burst_wr && cfg_mode == 2'd2) |=> (cell_q[3:1] == 3'b000));

   a_r6_carry_out: assert property (@(posedge clk) disable iff (!rst_n)
      (row_en && !burst_wr && cfg_mode == 2'd3 && !cfg_fb_en) |=> (cell_q[2] == $past(chk_sum[2])));
endmodule

bind dual_lut_cell dual_lut_cell_chk #(
   .NUM_IN  (NUM_IN),
   .NUM_OUT (NUM_OUT),
   .ADDR_W  (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cell_in    (cell_in),
   .row_en     (row_en),
   .burst_init (burst_init),
   .cfg_mode   (cfg_mode),
   .cfg_fb_en  (cfg_fb_en),
   .cell_q     (cell_q),
   .burst_wr   (burst_wr),
   .burst_done (burst_done),
   .burst_addr (burst_addr)
);

// File: tb/dual_lut_cell_test.sv
module dual_lut_cell_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] cell_in = '0;
   logic       row_en = 1'b0;
   logic       state_init = 1'b0;
   logic       burst_init = 1'b0;
   logic       burst_on = 1'b0;
   logic [7:0] burst_lanes = '0;
   logic [1:0] cfg_mode = '0;
   logic       cfg_fb_en = 1'b0;
   logic       cfg_init_src = 1'b0;
   logic       cfg_init_const = 1'b0;
   logic       cfg_run_src = 1'b0;
   logic [1:0] cfg_loop_sel = '0;
   logic [3:0] cell_q;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;
   logic [7:0] words [8];

   always #10 clk = ~clk;

   dual_lut_cell uut (
      .clk(clk), .rst_n(rst_n), .cell_in(cell_in), .row_en(row_en),
      .state_init(state_init), .burst_init(burst_init), .burst_on(burst_on),
      .burst_lanes(burst_lanes), .cfg_mode(cfg_mode), .cfg_fb_en(cfg_fb_en),
      .cfg_init_src(cfg_init_src), .cfg_init_const(cfg_init_const),
      .cfg_run_src(cfg_run_src), .cfg_loop_sel(cfg_loop_sel), .cell_q(cell_q)
   );

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: cell_q=%b expected=%b", req, act, exp);
      end
   endtask

   function automatic logic [1:0] ent(input int t, input int a);
      logic [7:0] w;
      w = words[t*4 + a/4];
      return w[2*(a%4) +: 2];
   endfunction

   // kind 0 identity, 1 pattern, 2 adder
   function automatic logic [1:0] gen_entry(input int kind, input int t, input int a);
      logic [7:0] pw;
      if (kind == 0) return (t == 0) ? 2'(a % 4) : 2'(a / 4);
      if (kind == 2) return 2'((a % 4) + (a / 4) + t);
      pw = 8'(((t*4 + a/4) * 37 + 11) % 256);
      return pw[2*(a%4) +: 2];
   endfunction

   function automatic logic [3:0] model(input int m, input logic [5:0] e);
      logic [1:0] p;
      p = e[4] ? ent(1, int'(e[3:0])) : ent(0, int'(e[3:0]));
      case (m)
         0: return {ent(1, int'(e[3:0])), ent(0, int'(e[3:0]))};
         1: return {2'b00, p};
         2: return {3'b000, p[e[5]]};
         default: return 4'b0000;
      endcase
   endfunction

   // full 8-word burst with R7 layout: word n -> table n/4, entries 4*(n%4)+k
   task automatic load_tables(input int kind);
      burst_init = 1'b1;
      cyc();
      burst_init = 1'b0;
      for (int n = 0; n < 8; n++) begin
         logic [7:0] w;
         for (int k = 0; k < 4; k++) w[2*k +: 2] = gen_entry(kind, n/4, 4*(n%4) + k);
         words[n] = w;
         burst_on = 1'b1;
         burst_lanes = w;
         cyc();
      end
      burst_on = 1'b0;
   endtask

   task automatic sweep(input int m, input int span, input string req);
      cfg_mode = 2'(m);
      row_en = 1'b1;
      for (int x = 0; x < span; x++) begin
         cell_in = 6'(x);
         cyc();
         check(req, cell_q, model(m, 6'(x)));
      end
   endtask

   initial begin
      logic [3:0] held;
      repeat (2) cyc();
      rst_n = 1'b1;
      row_en = 1'b1;
      cyc();
      check("R10 reset and empty tables", cell_q, 4'b0000);

      // identity tables: mode 0 echoes e[3:0]
      load_tables(0);
      sweep(0, 16, "R1 identity");

      // R4: row enable low holds
      cell_in = 6'b000101;
      cyc();
      held = cell_q;
      row_en = 1'b0;
      cell_in = 6'b001010;
      cyc();
      cyc();
      check("R4 hold with row_en low", cell_q, held);
      row_en = 1'b1;

      // R5 feedback sources
      cfg_fb_en = 1'b1;
      state_init = 1'b1;
      cfg_init_src = 1'b0;
      cfg_init_const = 1'b1;
      cell_in = 6'b000000;
      cyc();
      check("R5 init constant 1", cell_q, 4'b1000);
      cfg_init_const = 1'b0;
      cyc();
      check("R5 init constant 0", cell_q, 4'b0000);
      cfg_init_src = 1'b1;
      cell_in = 6'b100000;
      cyc();
      check("R5 init from input 5", cell_q, 4'b1000);
      cell_in = 6'b000000;
      cyc();
      check("R5 init from input 5 low", cell_q, 4'b0000);
      state_init = 1'b0;
      cfg_run_src = 1'b0;
      cfg_loop_sel = 2'd0;
      cell_in = 6'b000001;
      cyc();
      check("R5 loop first step", cell_q, 4'b0001);
      cyc();
      check("R5 loop second step", cell_q, 4'b1001);
      cfg_run_src = 1'b1;
      cell_in = 6'b010000;
      cyc();
      check("R5 run from input 4", cell_q, 4'b1000);
      cfg_fb_en = 1'b0;

      // R9: outputs hold while words are written
      cfg_mode = 2'd0;
      cell_in = 6'b000110;
      cyc();
      held = cell_q;
      burst_init = 1'b1;
      cyc();
      burst_init = 1'b0;
      for (int n = 0; n < 8; n++) begin
         logic [7:0] w;
         for (int k = 0; k < 4; k++) w[2*k +: 2] = gen_entry(1, n/4, 4*(n%4) + k);
         words[n] = w;
         burst_on = 1'b1;
         burst_lanes = w;
         cell_in = 6'(n * 5);
         cyc();
         check("R9 hold during burst", cell_q, held);
      end

      // R8: counter finished, extra burst cycles write nothing
      burst_lanes = 8'hFF;
      repeat (3) cyc();
      burst_on = 1'b0;
      sweep(0, 16, "R1 R7 R8 pattern 4:4");
      sweep(1, 64, "R2 pattern 5:2");
      sweep(2, 64, "R3 pattern 6:1");

      // R7: clear then rewrite word 0 only
      burst_init = 1'b1;
      cyc();
      burst_init = 1'b0;
      burst_on = 1'b1;
      burst_lanes = 8'hC6;
      words[0] = 8'hC6;
      cyc();
      burst_on = 1'b0;
      sweep(0, 16, "R7 partial rewrite");

      // R6 adder
      load_tables(2);
      cfg_mode = 2'd3;
      row_en = 1'b1;
      for (int x = 0; x < 32; x++) begin
         int a, b, c, sa, sb, tot, s;
         logic [3:0] exp;
         a = x % 4; b = (x / 4) % 4; c = x / 16;
         sa = (a >= 2) ? a - 4 : a;
         sb = (b >= 2) ? b - 4 : b;
         tot = sa + sb + c;
         s = a + b + c;
         exp = {(tot > 1 || tot < -2) ? 1'b1 : 1'b0, (s >= 4) ? 1'b1 : 1'b0, 2'(s % 4)};
         cell_in = 6'(x);
         cyc();
         check("R6 adder", cell_q, exp);
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      #(20 * 20000);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule